// File: doc/BRIEF.md
# Clocked Digital I/O Port

This block is one bidirectional digital port of a register-mapped I/O module. A host reaches it through a small register window: a data register and a control register. In the output direction the value the host writes sits in a holding register. In transparent mode that value drives the pins at once. In latched mode it moves to a second output buffer only when a selected clock event occurs. This lets many ports change their pins together on one shared event.

The clock event for each direction is picked from three sources: nothing (tied low), an asynchronous front-panel clock, or a one-cycle strobe that marks a write to a relay register elsewhere in the module. Each source has its own polarity bit, so the port acts on either the rising or the falling edge. In the input direction the chosen edge captures the pin levels into an input buffer, which the host then reads back. A data-polarity bit makes the pins active-low in both directions. The port drives its pins when the software direction bit or the external direction pin asks for output.

Asynchronous inputs (front-panel clock, direction pin, input pins) pass through synchronizer flops. Edge detection is done on the synchronized, polarity-adjusted level. A synchronous soft reset returns the port to its power-up state.

Top module: `dio_port`

## Requirements
- R1: After reset the control register reads 0, the pins drive 0xFF, and the output enable follows only the external direction pin.
- R2: In transparent mode (control bit 4 = 0), a host write to the data register (address 0) appears on the pins on the cycle after the write.
- R3: In latched mode (control bit 4 = 1), written data leaves the pins unchanged until an output clock event. After a front-panel clock edge driven between clocks, the pins update after the third rising system clock edge.
- R4: The output source field (control bits 2:1) selects 0 = none, 1 = front-panel clock, 2 = relay-write strobe, 3 = none. An unselected source causes no update. A selected relay strobe updates the pins on the clock edge that samples it.
- R5: The output polarity bit (control bit 3) set to 1 makes the port act on the falling edge of the selected source instead of the rising edge.
- R6: The output enable is the OR of control bit 0 and the external direction pin. The pin reaches the output enable after two clock edges; the control bit takes effect on the cycle after its write.
- R7: With the port in input direction, the selected input edge (source bits 6:5, same encoding as R4; polarity bit 7) captures the pins into the input buffer. A read of address 0 returns that buffer. No capture happens without an edge, or while the port is an output. In output direction, address 0 reads back the written data.
- R8: Data polarity (control bit 8) set to 1 inverts the pins with respect to the written data and inverts captured data on read.
- R9: A soft reset pulse sets the control register to 0 and both output buffers to 0xFF, and clears the input buffer.
- R10: Address 1 reads back control bits 8:0; a write to address 1 stores bits 8:0, and bits 15:9 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous soft reset pulse |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | 1 | Register select: 0 data, 1 control |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Read data for the selected register |
| relay_wr_evt | input | 1 | One-cycle relay-register write strobe |
| fp_clk | input | 1 | Asynchronous front-panel clock |
| dir_pin | input | 1 | Asynchronous external output request |
| pin_in | input | 8 | Pin levels seen by the input path |
| pin_out | output | 8 | Pin levels driven by the output path |
| pin_oe | output | 1 | Pin output enable |

## Verification
On every cycle the assertions check these behaviours: the event selector never fires for an unselected source; the latched output buffer and the input buffer stay stable without an event; a transparent write reaches the pins one cycle later; the control bit always forces the output enable; and a soft reset clears the control register. Only the bench scenarios can show the exact synchronizer latency of a front-panel edge and that the falling-edge setting moves the update to the end of a relay strobe. They also show that captured data survives later pin changes and a spell in output direction, and that the field encodings read back as specified. The cycle model in the bench compares pins, enable and read data after each clock across all of these scenarios.

// File: rtl/dio_port_pkg.sv
package dio_port_pkg;

    localparam logic [1:0] SRC_NONE  = 2'd0;
    localparam logic [1:0] SRC_FP    = 2'd1;
    localparam logic [1:0] SRC_RELAY = 2'd2;

    localparam int CTRL_W = 9;

    typedef struct packed {
        logic       data_inv;
        logic       in_fall;
        logic [1:0] in_src;
        logic       latched;
        logic       out_fall;
        logic [1:0] out_src;
        logic       dir_out;
    } ctrl_t;

endpackage

// File: rtl/dio_sync.sv
module dio_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] stage_q [STAGES];
    logic [W-1:0] stage_d [STAGES];

    always_comb begin
        stage_d[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[g] <= '0;
                else        stage_q[g] <= stage_d[g];
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/dio_evt_sel.sv
module dio_evt_sel
    import dio_port_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] src_sel,
    input  logic       fall,
    input  logic       fp_lvl,
    input  logic       relay_lvl,
    output logic       evt
);
    logic lvl, prev_d, prev_q;

    always_comb begin
        case (src_sel)
            SRC_FP:    lvl = fp_lvl;
            SRC_RELAY: lvl = relay_lvl;
            default:   lvl = 1'b0;
        endcase
        prev_d = lvl;
        evt    = fall ? (prev_q & ~lvl) : (lvl & ~prev_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end

    // R4: a source outside {front panel, relay} never produces an event
    p_idle_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (src_sel == SRC_NONE || src_sel == 2'd3) |-> !evt);
endmodule

// File: rtl/dio_port.sv
module dio_port
    import dio_port_pkg::*;
#(
    parameter int WIDTH       = 8,
    parameter int HOST_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              host_wr,
    input  logic              host_addr,
    input  logic [HOST_W-1:0] host_wdata,
    output logic [HOST_W-1:0] host_rdata,
    input  logic              relay_wr_evt,
    input  logic              fp_clk,
    input  logic              dir_pin,
    input  logic [WIDTH-1:0]  pin_in,
    output logic [WIDTH-1:0]  pin_out,
    output logic              pin_oe
);
    localparam int PAD_W = HOST_W - WIDTH;

    typedef struct packed {
        ctrl_t            ctrl;
        logic [WIDTH-1:0] hold;
        logic [WIDTH-1:0] obuf;
        logic [WIDTH-1:0] ibuf;
    } state_t;

    state_t st_d, st_q;

    logic             fp_s, dir_s;
    logic [WIDTH-1:0] pin_s;
    logic             out_evt, in_evt;
    logic [WIDTH-1:0] inv_mask;

    dio_sync #(.W(1), .STAGES(SYNC_STAGES)) u_fp_sync (
        .clk(clk), .rst_n(rst_n), .async_i(fp_clk), .sync_o(fp_s));
    dio_sync #(.W(1), .STAGES(SYNC_STAGES)) u_dir_sync (
        .clk(clk), .rst_n(rst_n), .async_i(dir_pin), .sync_o(dir_s));
    dio_sync #(.W(WIDTH), .STAGES(SYNC_STAGES)) u_pin_sync (
        .clk(clk), .rst_n(rst_n), .async_i(pin_in), .sync_o(pin_s));

    dio_evt_sel u_out_evt (
        .clk(clk), .rst_n(rst_n), .src_sel(st_q.ctrl.out_src),
        .fall(st_q.ctrl.out_fall), .fp_lvl(fp_s), .relay_lvl(relay_wr_evt),
        .evt(out_evt));
    dio_evt_sel u_in_evt (
        .clk(clk), .rst_n(rst_n), .src_sel(st_q.ctrl.in_src),
        .fall(st_q.ctrl.in_fall), .fp_lvl(fp_s), .relay_lvl(relay_wr_evt),
        .evt(in_evt));

    always_comb begin
        inv_mask = {WIDTH{st_q.ctrl.data_inv}};
        pin_oe   = st_q.ctrl.dir_out | dir_s;
        pin_out  = (st_q.ctrl.latched ? st_q.obuf : st_q.hold) ^ inv_mask;

        if (host_addr) begin
            host_rdata = {{(HOST_W-CTRL_W){1'b0}}, st_q.ctrl};
        end else if (pin_oe) begin
            host_rdata = {{PAD_W{1'b0}}, st_q.hold};
        end else begin
            host_rdata = {{PAD_W{1'b0}}, st_q.ibuf ^ inv_mask};
        end
    end

    always_comb begin
        st_d = st_q;
        if (soft_rst) begin
            st_d.ctrl = '0;
            st_d.hold = '1;
            st_d.obuf = '1;
            st_d.ibuf = '0;
        end else begin
            if (host_wr && !host_addr) st_d.hold = host_wdata[WIDTH-1:0];
            if (host_wr &&  host_addr) st_d.ctrl = ctrl_t'(host_wdata[CTRL_W-1:0]);
            if (!st_q.ctrl.latched || out_evt) st_d.obuf = st_q.hold;
            if (in_evt && !pin_oe) st_d.ibuf = pin_s;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ctrl <= '0;
            st_q.hold <= '1;
            st_q.obuf <= '1;
            st_q.ibuf <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R2: transparent write shows on the pins one cycle later
    p_transparent_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && !host_addr && !soft_rst && !st_q.ctrl.latched)
        |=> pin_out == ($past(host_wdata[WIDTH-1:0]) ^ {WIDTH{st_q.ctrl.data_inv}}));

    // R3: latched output buffer holds without an event
    p_latched_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ctrl.latched && !out_evt && !soft_rst) |=> $stable(st_q.obuf));

    // R6: software direction bit always enables the drivers
    p_dir_or_r6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ctrl.dir_out |-> pin_oe);

    // R7: input buffer only changes on a capture event
    p_in_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!(in_evt && !pin_oe) && !soft_rst) |=> $stable(st_q.ibuf));

    // R9: soft reset clears the control register
    p_soft_rst_r9: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (host_addr || host_rdata[CTRL_W-1:0] == '0) && st_q.ctrl == '0);
endmodule

// File: tb/dio_port_test.sv
module dio_port_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        soft_rst = 1'b0;
    logic        host_wr = 1'b0;
    logic        host_addr = 1'b0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic        relay_wr_evt = 1'b0;
    logic        fp_clk = 1'b0;
    logic        dir_pin = 1'b0;
    logic [7:0]  pin_in = '0;
    logic [7:0]  pin_out;
    logic        pin_oe;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    dio_port uut (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .host_wr(host_wr),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .relay_wr_evt(relay_wr_evt), .fp_clk(fp_clk), .dir_pin(dir_pin),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe));

    // behavioural reference model
    int m_ctrl, m_hold, m_obuf, m_ibuf;
    int fpq[$], dirq[$], pinq[$];
    int m_prev_o, m_prev_i;

    function automatic int src_lvl(int sel, int fp, int rl);
        if (sel == 1) return fp;
        if (sel == 2) return rl;
        return 0;
    endfunction

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int m_mask();
        return ((m_ctrl >> 8) & 1) ? 8'hFF : 0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ctrl = 0; m_hold = 8'hFF; m_obuf = 8'hFF; m_ibuf = 0;
            fpq = '{0, 0}; dirq = '{0, 0}; pinq = '{0, 0};
            m_prev_o = 0; m_prev_i = 0;
        end else begin
            int fp_now, dir_now, pin_now, lo, li, eo, ei, oe_now;
            int n_ctrl, n_hold, n_obuf, n_ibuf;
            fp_now = fpq[0]; dir_now = dirq[0]; pin_now = pinq[0];
            oe_now = (m_ctrl & 1) | dir_now;
            lo = src_lvl((m_ctrl >> 1) & 3, fp_now, relay_wr_evt);
            li = src_lvl((m_ctrl >> 5) & 3, fp_now, relay_wr_evt);
            eo = ((m_ctrl >> 3) & 1) ? (m_prev_o && !lo) : (lo && !m_prev_o);
            ei = ((m_ctrl >> 7) & 1) ? (m_prev_i && !li) : (li && !m_prev_i);
            m_prev_o = lo; m_prev_i = li;
            n_ctrl = m_ctrl; n_hold = m_hold; n_obuf = m_obuf; n_ibuf = m_ibuf;
            if (soft_rst) begin
                n_ctrl = 0; n_hold = 8'hFF; n_obuf = 8'hFF; n_ibuf = 0;
            end else begin
                if (host_wr && !host_addr) n_hold = host_wdata[7:0];
                if (host_wr &&  host_addr) n_ctrl = host_wdata[8:0];
                if (!((m_ctrl >> 4) & 1) || eo) n_obuf = m_hold;
                if (ei && !oe_now) n_ibuf = pin_now;
            end
            m_ctrl = n_ctrl; m_hold = n_hold; m_obuf = n_obuf; m_ibuf = n_ibuf;
            void'(fpq.pop_front());  fpq.push_back(fp_clk);
            void'(dirq.pop_front()); dirq.push_back(dir_pin);
            void'(pinq.pop_front()); pinq.push_back(pin_in);
            #2;
            begin
                int e_oe, e_pin, e_rd;
                e_oe  = (m_ctrl & 1) | dirq[0];
                e_pin = ((((m_ctrl >> 4) & 1) ? m_obuf : m_hold) ^ m_mask()) & 8'hFF;
                if (host_addr)  e_rd = m_ctrl;
                else if (e_oe)  e_rd = m_hold;
                else            e_rd = (m_ibuf ^ m_mask()) & 8'hFF;
                chk("model R3 pins", pin_out, e_pin);
                chk("model R6 oe", pin_oe, e_oe);
                chk("model R10 rdata", host_rdata, e_rd);
            end
        end
    end

    task automatic hwrite(input logic a, input logic [15:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0; host_addr = 1'b0;
    endtask

    task automatic relay_pulse();
        @(negedge clk); relay_wr_evt = 1'b1;
        @(negedge clk); relay_wr_evt = 1'b0;
    endtask

    task automatic fp_pulse();
        @(negedge clk); fp_clk = 1'b1;
        repeat (4) @(negedge clk);
        fp_clk = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic read_at(input logic a, output int v);
        @(negedge clk); host_addr = a;
        #1 v = host_rdata;
    endtask

    initial begin
        int v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 pins", pin_out, 8'hFF);
        chk("R1 oe", pin_oe, 0);
        read_at(1'b1, v); chk("R1 ctrl", v, 0);

        // R2 transparent
        hwrite(1'b0, 16'h005A);
        chk("R2 pins", pin_out, 8'h5A);

        // R3 latched, front-panel source
        hwrite(1'b1, 16'h0012);
        hwrite(1'b0, 16'h003C);
        chk("R3 held", pin_out, 8'h5A);
        @(negedge clk); fp_clk = 1'b1;
        repeat (2) @(negedge clk);
        chk("R3 before third edge", pin_out, 8'h5A);
        @(negedge clk);
        chk("R3 after third edge", pin_out, 8'h3C);
        repeat (2) @(negedge clk); fp_clk = 1'b0;
        repeat (4) @(negedge clk);

        // R4 relay source
        hwrite(1'b1, 16'h0014);
        hwrite(1'b0, 16'h00A5);
        chk("R4 waits", pin_out, 8'h3C);
        fp_pulse();
        chk("R4 fp ignored", pin_out, 8'h3C);
        relay_pulse();
        chk("R4 relay", pin_out, 8'hA5);
        // R4 none / value 3
        hwrite(1'b1, 16'h0010);
        hwrite(1'b0, 16'h0077);
        relay_pulse(); fp_pulse();
        chk("R4 none", pin_out, 8'hA5);
        hwrite(1'b1, 16'h0016);
        relay_pulse(); fp_pulse();
        chk("R4 sel3", pin_out, 8'hA5);

        // R5 falling edge on relay strobe
        hwrite(1'b1, 16'h001C);
        hwrite(1'b0, 16'h0011);
        @(negedge clk); relay_wr_evt = 1'b1;
        @(negedge clk); relay_wr_evt = 1'b0;
        chk("R5 not on rise", pin_out, 8'hA5);
        @(negedge clk);
        chk("R5 on fall", pin_out, 8'h11);

        // R6 direction
        hwrite(1'b1, 16'h0000);
        dir_pin = 1'b1;
        @(negedge clk); chk("R6 pin not yet", pin_oe, 0);
        @(negedge clk); chk("R6 pin", pin_oe, 1);
        dir_pin = 1'b0; repeat (2) @(negedge clk);
        chk("R6 released", pin_oe, 0);
        hwrite(1'b1, 16'h0001);
        chk("R6 sw bit", pin_oe, 1);

        // R7 input capture
        hwrite(1'b1, 16'h0020);
        pin_in = 8'h96;
        fp_pulse();
        read_at(1'b0, v); chk("R7 capture", v, 8'h96);
        pin_in = 8'h11; repeat (4) @(negedge clk);
        read_at(1'b0, v); chk("R7 no edge", v, 8'h96);
        hwrite(1'b1, 16'h0021);
        pin_in = 8'h44;
        fp_pulse();
        read_at(1'b0, v); chk("R7 output readback", v, 8'h11);
        hwrite(1'b1, 16'h0020);
        read_at(1'b0, v); chk("R7 no capture as output", v, 8'h96);

        // R8 data polarity
        hwrite(1'b1, 16'h0100);
        hwrite(1'b0, 16'h000F);
        chk("R8 pins", pin_out, 8'hF0);
        read_at(1'b0, v); chk("R8 read inverted", v, 8'h69);

        // R10 control readback
        hwrite(1'b1, 16'hFFFF);
        read_at(1'b1, v); chk("R10 ctrl", v, 16'h01FF);

        // R9 soft reset
        @(negedge clk); soft_rst = 1'b1;
        @(negedge clk); soft_rst = 1'b0;
        read_at(1'b1, v); chk("R9 ctrl", v, 0);
        chk("R9 pins", pin_out, 8'hFF);
        read_at(1'b0, v); chk("R9 ibuf", v, 0);

        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule